// File: doc/BRIEF.md
# Reference Clock Ratio Auto-Detector

This block works out which of three reference frequencies is driving the
reference input, so that the loop divider can pick its multiplication ratio
with no strapping or software setting. The oscillator runs at 16, 32 or 128
times the reference, and its nominal range is 2.5 to 2.7 GHz. The usable
reference bands therefore sit near 155, 78 and 19.5 MHz.

A free-running counter in the reference domain is Gray-coded and carried into
the system clock domain. Over a fixed window of system cycles, the block takes
the difference of that count. The result is an edge count per window, and it is
sorted into one of three inclusive bands, or into none of them. The choice is
re-made at every window for as long as the block runs. A new band has to be seen
in two windows in a row before the output code moves to it. A window with
almost no edges raises a dead-reference flag at once.

With the default parameters, the window is 200 cycles of a 200 MHz system clock,
which is 1 us. The edge count in a window is then the reference frequency in MHz.

Top module: `refclk_ratio_detect`

## Requirements
- R1: While reset is applied and on the first cycle after it is released, ratio_o is 2'b11, valid_o is 0 and ref_dead_o is 0.
- R2: A window is classified by the number of reference rising edges it contains, with inclusive bounds. A count of 130 to 200 means ratio 16, code 2'b00. A count of 60 to 100 means ratio 32, code 2'b01. A count of 15 to 25 means ratio 128, code 2'b10.
- R3: A count outside all three bands (for example 40, 110 or 250) is a window of class 2'b11. After two such windows in a row, ratio_o is 2'b11 and valid_o is 0.
- R4: ratio_o takes a new class only when the two most recent windows gave that same class. A single window of a different class leaves ratio_o unchanged.
- R5: valid_o is 1 exactly when ratio_o is not 2'b11.
- R6: A window with at most 1 reference edge sets ref_dead_o to 1 and forces ratio_o to 2'b11 in that same update, whatever the previous windows showed. The next window with 2 or more edges clears ref_dead_o.
- R7: Monitoring never stops. After any change of reference frequency, the outputs follow the new band or the invalid code without a reset. Outside the update cycles the outputs hold.
- R8: Each window is exactly WIN_CYC system cycles long, and the first window after reset is discarded. Outputs change only on the clock edge that follows a window close. Counting the first edge with reset released as edge 1, these are edges k*WIN_CYC+1 for k >= 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that times the measurement window |
| rst_ni | input | 1 | Synchronous active-low reset, in the system clock domain |
| ref_clk_i | input | 1 | Reference clock being measured |
| ratio_o | output | 2 | Detected ratio: 00 = x16, 01 = x32, 10 = x128, 11 = none |
| valid_o | output | 1 | High when ratio_o holds a supported ratio |
| ref_dead_o | output | 1 | High after a window with no meaningful reference activity |

## Verification
The bench goes after the exact update edge just after the third window close.
A window that is one cycle too long or short, or a first window that is kept,
would move the change by a cycle or a whole window. It sends a one-window burst
of another band while the output is locked. A design without the two-window rule
would flicker to the burst's code. It removes the reference just before a window
ends, so that the last partial window still falls in band. A design that let
only the two-window filter act on a dead reference would keep reporting the old
ratio for one window too long. It also moves between every valid band and three
invalid frequencies without reset, below, between and above the bands. This
catches bounds that are wrong or overlap, and a filter that locks up after an
invalid spell.

// File: rtl/rcd_pkg.sv
// Shared types for the reference ratio detector.
// Assumes: the code values are decoded by the loop divider and must not move.
package rcd_pkg;

    typedef enum logic [1:0] {
        RATIO_16   = 2'b00,
        RATIO_32   = 2'b01,
        RATIO_128  = 2'b10,
        RATIO_NONE = 2'b11
    } ratio_e;

endpackage

// File: rtl/rcd_edge_counter.sv
// Reference-domain edge counter. It counts rising edges of ref_clk_i and presents
// the count Gray-coded from a register, so that a sampling domain sees at most
// one bit change per step.
// Assumes: rst_ni comes from another domain and is re-timed here. The reference
// runs for a few edges during reset so that the counter clears.
module rcd_edge_counter #(
    parameter int unsigned CW = 10
) (
    input  logic          ref_clk_i,
    input  logic          rst_ni,
    output logic [CW-1:0] gray_o
);

    logic          rst_s1_q, rst_s2_q;
    logic [CW-1:0] bin_q;
    logic [CW-1:0] bin_next;

    // Re-time the reset into the reference domain.
    always_ff @(posedge ref_clk_i) begin
        rst_s1_q <= rst_ni;
        rst_s2_q <= rst_s1_q;
    end

    assign bin_next = bin_q + CW'(1);

    // Binary edge count and its registered Gray image.
    always_ff @(posedge ref_clk_i) begin
        if (!rst_s2_q) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_next;
            gray_o <= bin_next ^ (bin_next >> 1);
        end
    end

    // R7: the crossing stays safe only if the Gray value moves one bit per edge.
    p_gray_one_bit_r7: assert property (@(posedge ref_clk_i) disable iff (!rst_s2_q)
        rst_s2_q |=> ($countones(gray_o ^ $past(gray_o)) == 1));

endmodule

// File: rtl/rcd_window_meter.sv
// System-domain window meter. It synchronises the Gray count and turns it back
// into binary. A window of WIN_CYC cycles is timed here, and the edge count of
// each window is latched with a one-cycle done pulse. The first window after
// reset only primes the baseline.
// Assumes: fewer than 2**CW reference edges per window, and a reference slower
// than about twice the system clock.
module rcd_window_meter #(
    parameter int unsigned CW      = 10,
    parameter int unsigned WIN_CYC = 200
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] gray_i,
    output logic [CW-1:0] count_o,
    output logic          done_o
);

    localparam int unsigned TW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

    logic [TW-1:0] tmr_q;
    logic          tick;
    logic [CW-1:0] sync1_q, sync2_q;
    logic [CW-1:0] bin_now;
    logic [CW-1:0] base_q;
    logic          primed_q;

    assign tick = (tmr_q == TW'(WIN_CYC - 1));

    // Window timer, wrapping every WIN_CYC cycles.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tick ? '0 : tmr_q + TW'(1);
    end

    // Two-stage synchroniser for the Gray count.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= gray_i;
            sync2_q <= sync1_q;
        end
    end

    // Gray to binary: each bit is the parity of itself and all higher bits.
    always_comb begin
        for (int i = 0; i < int'(CW); i++) begin
            bin_now[i] = ^(sync2_q >> i);
        end
    end

    // Latch the edge difference at each window close, skipping the first window.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            base_q   <= '0;
            primed_q <= 1'b0;
            count_o  <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tick) begin
                base_q   <= bin_now;
                primed_q <= 1'b1;
                if (primed_q) begin
                    count_o <= bin_now - base_q;
                    done_o  <= 1'b1;
                end
            end
        end
    end

    // R8: a result lands only as a new window begins.
    p_done_aligned_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (tmr_q == '0));

    // R8: results are never back to back.
    p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

endmodule

// File: rtl/rcd_band_classifier.sv
// Combinational band sorter. It maps one window's edge count to a ratio class,
// with one comparator pair per band built by a generate loop.
// Assumes: the three bands do not overlap. A count in no band gives RATIO_NONE.
module rcd_band_classifier
    import rcd_pkg::*;
#(
    parameter int unsigned CW      = 10,
    parameter int unsigned B16_LO  = 130,
    parameter int unsigned B16_HI  = 200,
    parameter int unsigned B32_LO  = 60,
    parameter int unsigned B32_HI  = 100,
    parameter int unsigned B128_LO = 15,
    parameter int unsigned B128_HI = 25
) (
    input  logic [CW-1:0] count_i,
    output ratio_e        class_o
);

    localparam int unsigned NB = 3;
    localparam int unsigned LO   [NB] = '{B16_LO, B32_LO, B128_LO};
    localparam int unsigned HI   [NB] = '{B16_HI, B32_HI, B128_HI};
    localparam ratio_e      CODE [NB] = '{RATIO_16, RATIO_32, RATIO_128};

    logic [NB-1:0] hit;

    for (genvar g = 0; g < int'(NB); g++) begin : g_band
        assign hit[g] = (32'(count_i) >= LO[g]) && (32'(count_i) <= HI[g]);
    end

    // Select the class of the band that was hit.
    always_comb begin
        class_o = RATIO_NONE;
        for (int b = 0; b < int'(NB); b++) begin
            if (hit[b]) class_o = CODE[b];
        end
    end

    // R2: at most one band may claim a count.
    always_comb begin
        p_bands_disjoint_r2: assert ($onehot0(hit));
    end

endmodule

// File: rtl/refclk_ratio_detect.sv
// Reference clock ratio auto-detector, top level. It measures the reference
// against the system clock window by window and sorts each window into a ratio
// band. It commits a band only after two matching windows in a row, and flags a
// dead reference at once.
// Assumes: the system clock frequency and WIN_CYC are set so that the band
// bounds, given as edges per window, match the wanted frequencies.
module refclk_ratio_detect
    import rcd_pkg::*;
#(
    parameter int unsigned WIN_CYC  = 200,
    parameter int unsigned B16_LO   = 130,
    parameter int unsigned B16_HI   = 200,
    parameter int unsigned B32_LO   = 60,
    parameter int unsigned B32_HI   = 100,
    parameter int unsigned B128_LO  = 15,
    parameter int unsigned B128_HI  = 25,
    parameter int unsigned DEAD_MAX = 1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ref_clk_i,
    output logic [1:0] ratio_o,
    output logic       valid_o,
    output logic       ref_dead_o
);

    // Headroom of four times the top band before the counter difference aliases.
    localparam int unsigned CW = $clog2(B16_HI * 4 + 1);

    logic [CW-1:0] gray;
    logic [CW-1:0] win_count;
    logic          win_done;
    ratio_e        cand;
    ratio_e        prev_q;
    ratio_e        ratio_q;
    logic          dead_now;

    rcd_edge_counter #(.CW(CW)) u_cnt (
        .ref_clk_i (ref_clk_i),
        .rst_ni    (rst_ni),
        .gray_o    (gray)
    );

    rcd_window_meter #(.CW(CW), .WIN_CYC(WIN_CYC)) u_meter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .gray_i  (gray),
        .count_o (win_count),
        .done_o  (win_done)
    );

    rcd_band_classifier #(
        .CW(CW), .B16_LO(B16_LO), .B16_HI(B16_HI), .B32_LO(B32_LO),
        .B32_HI(B32_HI), .B128_LO(B128_LO), .B128_HI(B128_HI)
    ) u_cls (
        .count_i (win_count),
        .class_o (cand)
    );

    assign dead_now = (32'(win_count) <= DEAD_MAX);

    // Two-window commit filter, with an immediate override for a dead reference.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ratio_q    <= RATIO_NONE;
            prev_q     <= RATIO_NONE;
            ref_dead_o <= 1'b0;
        end else if (win_done) begin
            prev_q     <= cand;
            ref_dead_o <= dead_now;
            if (dead_now)            ratio_q <= RATIO_NONE;
            else if (cand == prev_q) ratio_q <= cand;
        end
    end

    assign ratio_o = ratio_q;
    assign valid_o = (ratio_q != RATIO_NONE);

    // R6: a dead reference never comes with a ratio.
    p_dead_forces_none_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_dead_o |-> (ratio_o == 2'b11) && !valid_o);

    // R7: outputs move only on a window result.
    p_hold_between_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !win_done |=> $stable(ratio_o) && $stable(ref_dead_o));

    // R4: a live window that disagrees with the previous one changes nothing.
    p_two_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_done && !dead_now && (cand != prev_q)) |=> $stable(ratio_o));

endmodule

// File: tb/sim_refclk_ratio_detect.sv
`timescale 1ps/1ps
module sim_refclk_ratio_detect;

    localparam int WIN = 200;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk = 1'b0;
    logic [1:0] ratio;
    logic       valid;
    logic       dead;

    int ref_id      = 1;       // 0 dead, 1 20MHz, 2 80MHz, 3 160MHz, 4 40MHz, 5 110MHz, 6 250MHz
    int change_edge = -100000;
    int edge_cnt    = 0;
    int n_checks    = 0;
    int n_fail      = 0;

    // Behavioural model state: value and whether it is known.
    int m_code = 3;  bit m_code_k = 1'b1;
    int m_prev = 3;  bit m_prev_k = 1'b1;
    int m_dead = 0;  bit m_dead_k = 1'b1;

    refclk_ratio_detect #(.WIN_CYC(WIN)) u0 (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ref_clk_i  (ref_clk),
        .ratio_o    (ratio),
        .valid_o    (valid),
        .ref_dead_o (dead)
    );

    always #2500 clk = ~clk;

    function automatic int half_ps(int id);
        case (id)
            1: return 25000;
            2: return 6250;
            3: return 3125;
            4: return 12500;
            5: return 4545;
            6: return 2000;
            default: return 25000;
        endcase
    endfunction

    function automatic int band_of(int id);
        case (id)
            1: return 2;
            2: return 1;
            3: return 0;
            default: return 3;
        endcase
    endfunction

    initial begin
        forever begin
            if (ref_id == 0) begin
                ref_clk = 1'b0;
                #1000;
            end else begin
                #(half_ps(ref_id));
                ref_clk = ~ref_clk;
            end
        end
    end

    always @(posedge clk) if (rst_n) edge_cnt <= edge_cnt + 1;

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edge_cnt);
        end
    endtask

    task automatic model_update();
        int  m;
        bit  clean;
        int  cand;
        m     = (edge_cnt - 1) / WIN;
        clean = (change_edge <= (m - 1) * WIN - 12);
        if (clean) begin
            cand     = band_of(ref_id);
            m_dead   = (ref_id == 0) ? 1 : 0;
            m_dead_k = 1'b1;
            if (m_dead == 1) begin
                m_code = 3; m_code_k = 1'b1;
            end else if (m_prev_k) begin
                if (cand == m_prev) begin
                    m_code = cand; m_code_k = 1'b1;
                end
            end else if (!(m_code_k && m_code == cand)) begin
                m_code_k = 1'b0;
            end
            m_prev   = cand;
            m_prev_k = 1'b1;
        end else begin
            m_dead_k = 1'b0;
            m_prev_k = 1'b0;
            m_code_k = 1'b0;
        end
    endtask

    // Per-cycle comparison against the model, at the falling edge.
    always @(negedge clk) begin
        if (rst_n && edge_cnt > 0) begin
            if (edge_cnt >= 2 * WIN + 1 && edge_cnt % WIN == 1) model_update();
            if (m_code_k) begin
                check("R7 model ratio", int'(ratio), m_code);
                check("R5 model valid", int'(valid), (m_code != 3) ? 1 : 0);
            end
            if (m_dead_k) check("R6 model dead", int'(dead), m_dead);
        end
    end

    task automatic goto_off(int off);
        do @(negedge clk); while (edge_cnt % WIN != off);
    endtask

    task automatic set_ref(int id);
        ref_id      = id;
        change_edge = edge_cnt;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (100) @(negedge clk);
        check("R1 reset ratio", int'(ratio), 3);
        check("R1 reset valid", int'(valid), 0);
        check("R1 reset dead", int'(dead), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle ratio", int'(ratio), 3);
        check("R1 first cycle dead", int'(dead), 0);

        while (edge_cnt != 2 * WIN + 5) @(negedge clk);
        check("R4 one window not enough", int'(ratio), 3);
        check("R6 live ref not dead", int'(dead), 0);

        while (edge_cnt != 3 * WIN) @(negedge clk);
        check("R8 before first commit", int'(ratio), 3);
        @(negedge clk);
        check("R8 commit at 3W+1", int'(ratio), 2);
        check("R2 20MHz is x128", int'(ratio), 2);
        check("R5 valid with ratio", int'(valid), 1);

        goto_off(10); set_ref(3); repeat (3 * WIN) @(negedge clk);
        check("R2 160MHz is x16", int'(ratio), 0);
        goto_off(10); set_ref(2); repeat (3 * WIN) @(negedge clk);
        check("R2 80MHz is x32", int'(ratio), 1);

        goto_off(10); set_ref(3); repeat (WIN) @(negedge clk);
        check("R4 single burst window held", int'(ratio), 1);
        set_ref(2); repeat (3 * WIN) @(negedge clk);
        check("R4 after burst", int'(ratio), 1);

        goto_off(10); set_ref(5); repeat (3 * WIN) @(negedge clk);
        check("R3 110MHz invalid", int'(ratio), 3);
        check("R5 invalid clears valid", int'(valid), 0);
        check("R3 110MHz not dead", int'(dead), 0);
        goto_off(10); set_ref(3); repeat (3 * WIN) @(negedge clk);
        check("R7 recover x16", int'(ratio), 0);
        goto_off(10); set_ref(6); repeat (3 * WIN) @(negedge clk);
        check("R3 250MHz invalid", int'(ratio), 3);
        goto_off(10); set_ref(1); repeat (3 * WIN) @(negedge clk);
        check("R7 recover x128", int'(ratio), 2);
        goto_off(10); set_ref(4); repeat (3 * WIN) @(negedge clk);
        check("R3 40MHz invalid", int'(ratio), 3);
        goto_off(10); set_ref(1); repeat (3 * WIN) @(negedge clk);
        check("R7 recover x128 again", int'(ratio), 2);

        goto_off(185); set_ref(0);
        goto_off(5);
        check("R6 partial window not dead", int'(dead), 0);
        check("R6 partial window keeps ratio", int'(ratio), 2);
        repeat (WIN) @(negedge clk);
        check("R6 dead flagged", int'(dead), 1);
        check("R6 dead forces none", int'(ratio), 3);
        check("R5 dead clears valid", int'(valid), 0);
        repeat (WIN) @(negedge clk);
        check("R6 stays dead", int'(dead), 1);

        goto_off(10); set_ref(1); repeat (3 * WIN) @(negedge clk);
        check("R6 dead clears", int'(dead), 0);
        check("R7 ratio after restart", int'(ratio), 2);

        summary();
        $finish;
    end

endmodule